// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in, and returns a 16-bit sum and a carry-out. It is built only from combinational logic, with no clock and no state. The operands are split into fixed-width groups, four bits wide by default. Inside each group, every carry is formed in one flat AND-OR level from the bit generate and propagate terms and the group's incoming carry. Between groups, the carry ripples: the top carry of one group is the incoming carry of the next.

The hybrid keeps the fan-in of the widest lookahead term bounded by the group width. The chain across groups is short enough that the worst path is about one lookahead level per group. A parent datapath drops the block in wherever a single-cycle add is needed. Subtraction and overflow detection are left to the surrounding logic.

Top module: `gcla_adder`

## Requirements
- R1: For every input, {cout_o, sum_o} equals a_i + b_i + cin_i taken as a 17-bit unsigned value.
- R2: With a_i = 16'hFFFF, b_i = 16'h0000 and cin_i = 1, sum_o is 16'h0000 and cout_o is 1. The same result holds for a_i = 16'hFFFF, b_i = 16'h0001 and cin_i = 0.
- R3: When a_i XOR b_i is all ones and cin_i is 0, sum_o is 16'hFFFF and cout_o is 0.
- R4: When a_i XOR b_i is all ones and cin_i is 1, sum_o is 16'h0000 and cout_o is 1.
- R5: With both operands zero, sum_o equals the zero-extended cin_i and cout_o is 0.
- R6: A carry generated at the top bit of one group enters the lowest bit of the next group. The carry into each group equals the carry out of the addition of all lower bits.
- R7: cout_o is the carry out of the most significant group. Setting both operand MSBs with no other carry source gives cout_o = 1 and sum_o = 0.
- R8: Swapping a_i and b_i leaves sum_o and cout_o unchanged.
- R9: The outputs depend only on the present inputs, with no clock and no stored state. A new input value shows its result in the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
Every result is due zero clock cycles after its inputs change, because no register lies on any path. The bench applies each vector on the falling edge of its free-running clock. It then waits one nanosecond for the combinational network to settle and samples sum_o and cout_o well before the next rising edge. The checker evaluates its relations whenever the inputs or internal group carries change. It skips any evaluation while an input is still unknown.

// File: rtl/gcla_pkg.sv
package gcla_pkg;
  parameter int unsigned GCLA_WIDTH   = 16;
  parameter int unsigned GCLA_GROUP_W = 4;

  typedef struct packed {
    logic g;
    logic p;
    logic h;
  } gcla_bit_t;
endpackage

// File: rtl/gcla_pg.sv
module gcla_pg
  import gcla_pkg::*;
#(
  parameter int unsigned GW = GCLA_GROUP_W
) (
  input  logic [GW-1:0] x_i,
  input  logic [GW-1:0] y_i,
  output logic [GW-1:0] g_o,
  output logic [GW-1:0] p_o,
  output logic [GW-1:0] h_o
);
  for (genvar k = 0; k < GW; k++) begin : g_bit
    gcla_bit_t bt;
    always_comb begin
      bt.g = x_i[k] & y_i[k];
      bt.p = x_i[k] | y_i[k];
      bt.h = x_i[k] ^ y_i[k];
    end
    assign g_o[k] = bt.g;
    assign p_o[k] = bt.p;
    assign h_o[k] = bt.h;
  end
endmodule

// File: rtl/gcla_lookahead.sv
module gcla_lookahead
  import gcla_pkg::*;
#(
  parameter int unsigned GW = GCLA_GROUP_W
) (
  input  logic [GW-1:0] g_i,
  input  logic [GW-1:0] p_i,
  input  logic          c_i,
  output logic [GW:0]   c_o
);
  if (GW == 4) begin : g_w4
    // flat two-level equations, each carry from c_i and g/p only
    always_comb begin
      c_o[0] = c_i;
      c_o[1] = g_i[0] | (p_i[0] & c_i);
      c_o[2] = g_i[1] | (p_i[1] & g_i[0]) | (p_i[1] & p_i[0] & c_i);
      c_o[3] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0])
             | (p_i[2] & p_i[1] & p_i[0] & c_i);
      c_o[4] = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
             | (p_i[3] & p_i[2] & p_i[1] & g_i[0])
             | (p_i[3] & p_i[2] & p_i[1] & p_i[0] & c_i);
    end
  end else begin : g_wn
    // same sum-of-products form, unrolled for any width
    always_comb begin
      logic prod;
      c_o[0] = c_i;
      for (int k = 0; k < GW; k++) begin
        c_o[k+1] = 1'b0;
        for (int j = 0; j <= k; j++) begin
          prod = g_i[j];
          for (int m = j + 1; m <= k; m++) prod = prod & p_i[m];
          c_o[k+1] = c_o[k+1] | prod;
        end
        prod = c_i;
        for (int m = 0; m <= k; m++) prod = prod & p_i[m];
        c_o[k+1] = c_o[k+1] | prod;
      end
    end
  end
endmodule

// File: rtl/gcla_group.sv
module gcla_group
  import gcla_pkg::*;
#(
  parameter int unsigned GW = GCLA_GROUP_W
) (
  input  logic [GW-1:0] x_i,
  input  logic [GW-1:0] y_i,
  input  logic          c_i,
  output logic [GW-1:0] s_o,
  output logic          c_o
);
  logic [GW-1:0] g, p, h;
  logic [GW:0]   c;

  gcla_pg #(.GW(GW)) u_pg (
    .x_i(x_i), .y_i(y_i), .g_o(g), .p_o(p), .h_o(h)
  );

  gcla_lookahead #(.GW(GW)) u_la (
    .g_i(g), .p_i(p), .c_i(c_i), .c_o(c)
  );

  // partial full adders
  for (genvar k = 0; k < GW; k++) begin : g_pfa
    assign s_o[k] = h[k] ^ c[k];
  end

  assign c_o = c[GW];
endmodule

// File: rtl/gcla_adder.sv
module gcla_adder
  import gcla_pkg::*;
#(
  parameter int unsigned W  = GCLA_WIDTH,
  parameter int unsigned GW = GCLA_GROUP_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned NG = W / GW;

  if (NG * GW != W || NG == 0) begin : g_bad_cfg
    initial $error("gcla_adder: W must be a nonzero multiple of GW");
  end

  logic [NG:0] grp_c;
  assign grp_c[0] = cin_i;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    gcla_group #(.GW(GW)) u_grp (
      .x_i(a_i[gi*GW +: GW]),
      .y_i(b_i[gi*GW +: GW]),
      .c_i(grp_c[gi]),
      .s_o(sum_o[gi*GW +: GW]),
      .c_o(grp_c[gi+1])
    );
  end

  assign cout_o = grp_c[NG];
endmodule

// File: rtl/gcla_adder_chk.sv
module gcla_adder_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned GW = 4,
  localparam int unsigned NG = W / GW
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cin_i,
  input logic [W-1:0] sum_o,
  input logic         cout_o,
  input logic [NG:0]  grp_c
);
  logic known;
  assign known = !$isunknown({a_i, b_i, cin_i});

  always_comb begin
    if (known) begin
      a_r1_sum_exact: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
        else $error("R1 sum mismatch");
      a_r7_cout_last_group: assert (cout_o == grp_c[NG])
        else $error("R7 cout not from last group");
      if ((a_i ^ b_i) == {W{1'b1}}) begin
        a_r3_r4_prop_chain: assert (sum_o == {W{~cin_i}} && cout_o == cin_i)
          else $error("R3/R4 propagate chain");
      end
      if (a_i == '0 && b_i == '0) begin
        a_r5_zero_add: assert (sum_o == {{(W-1){1'b0}}, cin_i} && !cout_o)
          else $error("R5 zero add");
      end
    end
  end

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp_chk
    always_comb begin
      if (known && !$isunknown(grp_c[gi])) begin
        a_r6_group_carry: assert ({grp_c[gi+1], sum_o[gi*GW +: GW]} ==
                                  ({1'b0, a_i[gi*GW +: GW]} + {1'b0, b_i[gi*GW +: GW]} + {{GW{1'b0}}, grp_c[gi]}))
          else $error("R6 group carry");
      end
    end
  end
endmodule

bind gcla_adder gcla_adder_chk #(.W(W), .GW(GW)) u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
  .sum_o(sum_o), .cout_o(cout_o), .grp_c(grp_c)
);

// File: tb/gcla_adder_tb.sv
`timescale 1ns/1ps
module gcla_adder_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a, b, sum;
  logic        cin, cout;
  int          checks = 0;
  int          failures = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gcla_adder u_dut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  function automatic logic [16:0] model(logic [15:0] x, logic [15:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {16'd0, c};
  endfunction

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%05h exp=%05h (a=%04h b=%04h cin=%0b)", req, act, exp, a, b, cin);
    end
  endtask

  task automatic apply(logic [15:0] x, logic [15:0] y, logic c);
    @(negedge clk);
    a = x; b = y; cin = c;
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=%0d exp=<100000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [16:0] r0;
    a = '0; b = '0; cin = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // R9: no state, result due in the same time step
    apply(16'h0000, 16'h0000, 1'b0);
    check("R9 idle", {cout, sum}, 17'h00000);
    a = 16'h1234; b = 16'h1111; #0.5;
    check("R9 same step", {cout, sum}, 17'h02345);

    apply(16'h0000, 16'h0000, 1'b1);
    check("R5 zero cin1", {cout, sum}, 17'h00001);
    apply(16'h0000, 16'h0000, 1'b0);
    check("R5 zero cin0", {cout, sum}, 17'h00000);

    apply(16'hFFFF, 16'h0000, 1'b1);
    check("R2 ones+cin", {cout, sum}, 17'h10000);
    apply(16'hFFFF, 16'h0001, 1'b0);
    check("R2 ones+1", {cout, sum}, 17'h10000);

    apply(16'hA5A5, 16'h5A5A, 1'b0);
    check("R3 prop cin0", {cout, sum}, 17'h0FFFF);
    apply(16'hFFFF, 16'h0000, 1'b0);
    check("R3 prop ones", {cout, sum}, 17'h0FFFF);
    apply(16'hA5A5, 16'h5A5A, 1'b1);
    check("R4 prop cin1", {cout, sum}, 17'h10000);
    apply(16'h0F0F, 16'hF0F0, 1'b1);
    check("R4 prop alt", {cout, sum}, 17'h10000);

    apply(16'h00F0, 16'h0010, 1'b0);
    check("R6 g1 to g2", {cout, sum}, 17'h00100);
    apply(16'h0FFF, 16'h0001, 1'b0);
    check("R6 through groups", {cout, sum}, 17'h01000);
    apply(16'h0008, 16'h0008, 1'b0);
    check("R6 g0 to g1", {cout, sum}, 17'h00010);

    apply(16'h8000, 16'h8000, 1'b0);
    check("R7 msb carry", {cout, sum}, 17'h10000);
    apply(16'hF000, 16'h1000, 1'b0);
    check("R7 top group", {cout, sum}, 17'h10000);

    void'($urandom(32'd1729));
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] x, y;
      logic        c;
      x = 16'($urandom); y = 16'($urandom); c = 1'($urandom);
      if (i % 4 == 1) y = ~x;
      if (i % 8 == 3) x = 16'hFFFF;
      apply(x, y, c);
      check("R1 random", {cout, sum}, model(x, y, c));
      if (i % 50 == 0) begin
        r0 = {cout, sum};
        apply(y, x, c);
        check("R8 swap", {cout, sum}, r0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule